// File: doc/BRIEF.md
# Cache Range Operation Splitter

This block accepts one cache maintenance request, given as a start byte address, an end byte address and an operation code. It turns the request into a series of commands for a downstream maintenance queue. The range is widened outward to whole cache lines. It is then cut into chunks, and no chunk is larger than the configured maximum less one line. The chunks are issued in ascending address order. After the last chunk the block always sends a sync command.

When the unrounded span reaches the top line of the address space, range commands are not used. The block sends one whole-cache command and then the sync.

Each command is sent over a valid/ready handshake. After a command is accepted, the block waits for the downstream queue to pulse its completion before it presents the next command. The request side stays not-ready until the completion of the final sync.

Top module: `cache_range_splitter`

## Requirements
- R1: Coming out of reset, `req_ready` is 1 and `cmd_valid` is 0.
- R2: The first range command's address is the request start rounded down to a multiple of `LINE_BYTES`. Every range command address is line aligned.
- R3: The range command sizes add up to (end − aligned start), taken modulo 2^`ADDR_W` and rounded up to a multiple of `LINE_BYTES`. Each command address is the previous address plus the previous size, modulo 2^`ADDR_W`.
- R4: Every range command size is nonzero, a multiple of the line size and at most `MAX_CHUNK − LINE_BYTES`. Every chunk except the last has exactly that maximum size.
- R5: If the unrounded span (end − aligned start, modulo 2^`ADDR_W`) is at least 2^`ADDR_W` − `LINE_BYTES`, exactly one whole-cache command is issued (`cmd_kind` = 1, address 0, size 0) and no range command.
- R6: Every request ends with exactly one sync command (`cmd_kind` = 2, op 0, address 0, size 0).
- R7: If end equals the aligned start, the only command issued is the sync.
- R8: Range commands (`cmd_kind` = 0) and whole-cache commands carry the request's op code unchanged. The op codes are 0 = invalidate, 1 = clean, 2 = flush.
- R9: While `cmd_valid` is high and `cmd_ready` is low, all command fields stay stable. After an acceptance, `cmd_valid` stays low until a `cmd_done` pulse has been seen.
- R10: `req_ready` falls on the cycle after a request is accepted. It stays low until the cycle after the sync's `cmd_done`, and then rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Byte address one past the range |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| cmd_valid | output | 1 | Command presented downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_kind | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_op | output | 2 | Operation code of the command |
| cmd_addr | output | ADDR_W | Range command start address |
| cmd_size | output | ADDR_W | Range command byte count |
| cmd_done | input | 1 | One-cycle completion pulse for the accepted command |

## Verification
The bench sweeps start offsets across lines against a set of span lengths on a 12-bit address space with 16-byte lines and a 48-byte chunk cap. The spans straddle the chunk boundary by one byte and by one line.

Several cases target specific faults:
- An end that falls inside the start's own line, or exactly on the aligned start, catches a splitter that issues a zero-size range or skips the sync.
- Spans one below and at the whole-cache threshold catch an off-by-one in the fallback: such a design sends 85 chunks where one whole-cache command belongs, or the reverse.
- A range that wraps past the top of the address space catches an address adder that saturates or carries.
- Delayed ready and delayed completion catch a design that moves its fields early or overlaps commands.

// File: rtl/crs_pkg.sv
// Shared types for the cache range splitter.
// Assumes: command kind encoding is visible at the top ports as 2 bits.
package crs_pkg;
    typedef enum logic [1:0] {
        KIND_RANGE = 2'd0,
        KIND_ALL   = 2'd1,
        KIND_SYNC  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/crs_req_decode.sv
// Request decode: aligns the start to a line and derives the rounded span.
// It also flags spans that require a whole-cache command.
// Assumes: LINE_BYTES is a power of two and smaller than 2**ADDR_W.
module crs_req_decode #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] span,
    output logic              whole
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] WHOLE_TH = ADDR_W'(0) - ADDR_W'(LINE_BYTES);

    logic [ADDR_W-1:0] raw_span;

    // Round start down, measure the wrapped span, round the span up.
    always_comb begin
        base_addr = req_start & ~LOW_MASK;
        raw_span  = req_end - base_addr;
        whole     = (raw_span >= WHOLE_TH);
        span      = (raw_span + LOW_MASK) & ~LOW_MASK;
    end
endmodule

// File: rtl/crs_chunk_sel.sv
// Chunk selection: the next range size is the remaining bytes, capped at the limit.
// Assumes: LIMIT is a positive multiple of the line size that fits in ADDR_W.
module crs_chunk_sel #(
    parameter int ADDR_W = 32,
    parameter int LIMIT  = 4194240
) (
    input  logic [ADDR_W-1:0] remain,
    output logic [ADDR_W-1:0] chunk
);
    localparam logic [ADDR_W-1:0] LIM = ADDR_W'(LIMIT);

    // Pick min(remain, LIM).
    always_comb begin
        chunk = (remain <= LIM) ? remain : LIM;
    end
endmodule

// File: rtl/crs_sequencer.sv
// Command sequencer: holds one request and issues range/whole/sync commands one
// at a time. It waits for the completion pulse after each acceptance.
// Assumes: cmd_done arrives only for a command that has been accepted.
module crs_sequencer
    import crs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LIMIT      = 4194240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] span,
    input  logic              whole,
    output logic [ADDR_W-1:0] remain,
    input  logic [ADDR_W-1:0] chunk,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] cmd_size,
    input  logic              cmd_done
);
    localparam int LINE_LG = $clog2(LINE_BYTES);

    seq_state_e        state_q;
    cmd_kind_e         kind_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] remain_q;

    // State, cursor and remaining-byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= KIND_SYNC;
            op_q     <= '0;
            addr_q   <= '0;
            remain_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= req_op;
                        addr_q  <= base_addr;
                        state_q <= ST_ISSUE;
                        if (whole) begin
                            kind_q   <= KIND_ALL;
                            remain_q <= '0;
                        end else if (span == '0) begin
                            kind_q   <= KIND_SYNC;
                            remain_q <= '0;
                        end else begin
                            kind_q   <= KIND_RANGE;
                            remain_q <= span;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        if (kind_q == KIND_RANGE) begin
                            addr_q   <= addr_q + chunk;
                            remain_q <= remain_q - chunk;
                        end
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cmd_done) begin
                        if (kind_q == KIND_RANGE && remain_q != '0) begin
                            state_q <= ST_ISSUE;
                        end else if (kind_q != KIND_SYNC) begin
                            kind_q  <= KIND_SYNC;
                            state_q <= ST_ISSUE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake and command fields from the registered state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_ISSUE);
        cmd_kind  = kind_q;
        cmd_op    = (kind_q == KIND_SYNC) ? 2'd0 : op_q;
        cmd_addr  = (kind_q == KIND_RANGE) ? addr_q : '0;
        cmd_size  = (kind_q == KIND_RANGE) ? chunk : '0;
        remain    = remain_q;
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) &&
                                       $stable(cmd_addr) && $stable(cmd_size) && $stable(cmd_op)));

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R10
    busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && cmd_valid));

    // R4
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == KIND_RANGE) |->
            (cmd_size != '0 && cmd_size <= ADDR_W'(LIMIT) &&
             cmd_size[LINE_LG-1:0] == '0));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == KIND_RANGE) |-> (cmd_addr[LINE_LG-1:0] == '0));

    // R6
    sync_follows_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && kind_q == KIND_ALL && cmd_done) |=>
            (cmd_valid && cmd_kind == KIND_SYNC));
endmodule

// File: rtl/cache_range_splitter.sv
// Top: splits a byte-range maintenance request into line-aligned capped chunks
// (or one whole-cache command), then a sync, over a valid/ready handshake.
// Assumes: LINE_BYTES a power of two, MAX_CHUNK a multiple of LINE_BYTES above it.
module cache_range_splitter #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_CHUNK  = 1 << 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [1:0]        req_op,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] cmd_size,
    input  logic              cmd_done
);
    localparam int CHUNK_LIMIT = MAX_CHUNK - LINE_BYTES;

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] span;
    logic              whole;
    logic [ADDR_W-1:0] remain;
    logic [ADDR_W-1:0] chunk;

    crs_req_decode #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_decode (
        .req_start (req_start),
        .req_end   (req_end),
        .base_addr (base_addr),
        .span      (span),
        .whole     (whole)
    );

    crs_chunk_sel #(.ADDR_W(ADDR_W), .LIMIT(CHUNK_LIMIT)) i_chunk (
        .remain (remain),
        .chunk  (chunk)
    );

    crs_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LIMIT(CHUNK_LIMIT)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .base_addr (base_addr),
        .span      (span),
        .whole     (whole),
        .remain    (remain),
        .chunk     (chunk),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_kind  (cmd_kind),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_size  (cmd_size),
        .cmd_done  (cmd_done)
    );
endmodule

// File: tb/test_cache_range_splitter.sv
`timescale 1ns/1ps
module test_cache_range_splitter;
    localparam int AW    = 12;
    localparam int LB    = 16;
    localparam int MX    = 64;
    localparam int LIM   = MX - LB;
    localparam int SPACE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic [1:0]    req_op = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [AW-1:0] cmd_size;
    logic          cmd_done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cache_range_splitter #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_CHUNK(MX)) i_cache_range_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_end(req_end), .req_op(req_op),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .cmd_done(cmd_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expect one command at the current negedge, then accept and complete it.
    task automatic expect_cmd(input int kind, input int op, input int addr, input int size,
                              input string tag, input int rd, input int dd);
        int exp_pk;
        int act_pk;
        exp_pk = (1 << 28) | (kind << 26) | (op << 24) | (addr << 12) | size;
        act_pk = (int'(cmd_valid) << 28) | (int'(cmd_kind) << 26) | (int'(cmd_op) << 24) |
                 (int'(cmd_addr) << 12) | int'(cmd_size);
        check(act_pk == exp_pk, tag, act_pk, exp_pk);
        for (int i = 0; i < rd; i++) begin
            @(negedge clk);
            act_pk = (int'(cmd_valid) << 28) | (int'(cmd_kind) << 26) | (int'(cmd_op) << 24) |
                     (int'(cmd_addr) << 12) | int'(cmd_size);
            check(act_pk == exp_pk, "R9 held command", act_pk, exp_pk);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        check(!cmd_valid && !req_ready, "R9 R10 after accept", {cmd_valid, req_ready}, 0);
        for (int i = 0; i < dd; i++) begin
            @(negedge clk);
            check(!cmd_valid && !req_ready, "R9 R10 awaiting done", {cmd_valid, req_ready}, 0);
        end
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    // Issue one request and follow the whole expected command sequence.
    task automatic run_req(input int s, input int e, input int op, input int rd, input int dd);
        int al;
        int raw;
        int rnd;
        int addr;
        int ch;
        s   = s & (SPACE - 1);
        e   = e & (SPACE - 1);
        al  = s & ~(LB - 1);
        raw = (e - al) & (SPACE - 1);
        check(req_ready && !cmd_valid, "R10 idle before request", {req_ready, cmd_valid}, 2);
        req_valid = 1'b1;
        req_start = AW'(s);
        req_end   = AW'(e);
        req_op    = 2'(op);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 busy after accept", int'(req_ready), 0);
        if (raw >= SPACE - LB) begin
            expect_cmd(1, op, 0, 0, "R5 R8 whole command", rd, dd);
        end else begin
            rnd  = (raw + LB - 1) & ~(LB - 1);
            addr = al;
            while (rnd > 0) begin
                ch = (rnd < LIM) ? rnd : LIM;
                expect_cmd(0, op, addr & (SPACE - 1), ch, "R2 R3 R4 R8 range command", rd, dd);
                addr = addr + ch;
                rnd  = rnd - ch;
            end
        end
        expect_cmd(2, 0, 0, 0, (raw == 0) ? "R6 R7 lone sync" : "R6 closing sync", rd, dd);
        check(req_ready && !cmd_valid, "R10 idle after sync", {req_ready, cmd_valid}, 2);
    endtask

    initial begin
        int offs[12] = '{0, 1, 15, 16, 17, 47, 48, 49, 95, 96, 97, 200};
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready && !cmd_valid, "R1 reset state", {req_ready, cmd_valid}, 2);
        for (int s = 0; s < 64; s += 3) begin
            for (int j = 0; j < 12; j++) begin
                run_req(s, s + offs[j], k % 3, k % 3, (k / 3) % 4);
                // R7: end exactly on the aligned start
                run_req(s, s & ~(LB - 1), k % 3, 0, 1);
                k++;
            end
        end
        // R5 thresholds: one below is 85 chunks, at and above is whole cache
        run_req(32, 15, 0, 1, 0);
        run_req(32, 16, 1, 0, 2);
        run_req(32, 31, 2, 2, 1);
        // R2 R3: end inside the start's line, wrap past top of address space
        run_req(37, 33, 1, 0, 0);
        run_req(4090, 20, 2, 1, 1);
        run_req(4081, 4081 + 100, 0, 0, 3);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule